// File: doc/BRIEF.md
# Edge-Selectable Latched Interrupt Controller

This block gathers 32 status flags into a single interrupt request. On each source it watches one transition of the flag, the rising one or the falling one as software selects. When that transition occurs on a source that is enabled, a sticky status bit is set. Every set status bit is ORed onto one request line. Software sees the cause by reading the status register, and it clears a cause by writing a one to that bit. Turning a source off also drops its pending bit.

A small register port with a two-bit address, a write strobe, write data and combinational read data gives access to four registers:

| Address | Register | Access |
|---|---|---|
| 0 | enable | read/write |
| 1 | status | write one to clear |
| 2 | polarity | read/write; 1 = rising, 0 = falling |
| 3 | trigger kind | read-only |

Every register uses bit n for source n. Each source whose index is a multiple of four is reserved. A reserved source never latches, and its bit reads 0 in every register. Each flag input is sampled into a register once per cycle, and a transition is detected by comparing the current value with the sampled value.

Top module: `irq_edge_latch_top`

## Requirements
- R1: After reset, the enable, status and polarity registers read 0 and `irqReq` is low.
- R2: Writes to enable (address 0) and polarity (address 2) read back as written, except that bits whose index is a multiple of four always read 0.
- R3: When an enabled source has its polarity bit at 1, a 0-to-1 change of its flag sets its status bit. The bit is visible on the first clock edge that samples the new flag value. A 1-to-0 change sets nothing.
- R4: When an enabled source has its polarity bit at 0, a 1-to-0 change of its flag sets its status bit with the same timing as R3. A 0-to-1 change sets nothing.
- R5: A source whose enable bit is 0 never sets its status bit, whatever its flag does.
- R6: A set status bit stays set until a write to address 1 has a 1 in that bit position. Writing 0 in that position leaves the bit unchanged.
- R7: A status clear write that has ones only in positions that are clear, disabled or reserved leaves the status register unchanged.
- R8: A write to the enable register that turns a source off clears that source's status bit on the same clock edge.
- R9: A qualifying flag transition that is sampled on the same edge as a clear write to that bit leaves the bit set.
- R10: The trigger-kind register (address 3) reads 1 for every non-reserved source and 0 for every reserved one (0xEEEEEEEE with the defaults). Writes to it have no effect.
- R11: `irqReq` is high exactly when at least one status bit is set.
- R12: A reserved source (index a multiple of four) never sets its status bit under any polarity, enable or flag activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcFlag | input | 32 | Status flags, one per source |
| regAddr | input | 2 | Register select |
| regWrEn | input | 1 | Write strobe for the selected register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the selected register, combinational |
| irqReq | output | 1 | Combined interrupt request |

## Verification
A register write takes effect on the clock edge that samples the strobe. Read data follows `regAddr` in the same cycle, with no edge in between. A flag transition appears in status and on `irqReq` on the first edge that samples the new flag value, which is one edge after the flag changes. The bench changes every input at a falling clock edge and reads back at the next falling edge, so each result is sampled exactly one edge after the stimulus that causes it. It sweeps every source under both polarities, and it also checks the disabled, reserved, same-edge-clear and partial-clear cases against masks that it computes arithmetically.

// File: rtl/irq_edge_pkg.sv
package irq_edge_pkg;

  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_ENABLE   = 2'd0,
    REG_STATUS   = 2'd1,
    REG_POLARITY = 2'd2,
    REG_KIND     = 2'd3
  } regSel_t;

  // Write strobes from the control decode to the datapath
  typedef struct packed {
    logic wrEnable;
    logic wrPolarity;
    logic clrStatus;
  } regStrobes_t;

endpackage

// File: rtl/irq_reg_ctrl.sv
module irq_reg_ctrl
  import irq_edge_pkg::*;
(
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  output regStrobes_t           strobes
);

  always_comb begin
    strobes = '0;
    if (regWrEn) begin
      case (regSel_t'(regAddr))
        REG_ENABLE:   strobes.wrEnable   = 1'b1;
        REG_STATUS:   strobes.clrStatus  = 1'b1;
        REG_POLARITY: strobes.wrPolarity = 1'b1;
        default:      strobes            = '0;   // trigger kind is read-only
      endcase
    end
  end

endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk,
  input  logic rstN,
  input  logic flagIn,
  input  logic wrEnable,
  input  logic wrPolarity,
  input  logic clrStatus,
  input  logic wrBit,
  output logic enQ,
  output logic polQ,
  output logic statQ
);

  logic prevQ;
  logic enNext;
  logic evtHit;
  logic statNext;

  assign enNext = wrEnable ? wrBit : enQ;
  // polQ = 1 selects the rising transition, 0 the falling one
  assign evtHit = polQ ? (flagIn & ~prevQ) : (~flagIn & prevQ);
  // the clear is applied first and a new event is ORed in after it, so a
  // same-edge event wins; the next enable value gates the result
  assign statNext = ((statQ & ~(clrStatus & wrBit)) | evtHit) & enNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ <= 1'b0;
      enQ   <= 1'b0;
      polQ  <= 1'b0;
      statQ <= 1'b0;
    end else begin
      prevQ <= flagIn;
      enQ   <= enNext;
      statQ <= statNext;
      if (wrPolarity) polQ <= wrBit;
    end
  end

endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_edge_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int RESV_STRIDE = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcFlag,
  input  regStrobes_t        strobes,
  input  logic [NUM_SRC-1:0] wrData,
  output logic [NUM_SRC-1:0] enableQ,
  output logic [NUM_SRC-1:0] polarityQ,
  output logic [NUM_SRC-1:0] statusQ
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if ((i % RESV_STRIDE) == 0) begin : g_resv
      logic unusedResvBit;
      assign unusedResvBit = srcFlag[i] ^ wrData[i];
      assign enableQ[i]    = 1'b0;
      assign polarityQ[i]  = 1'b0;
      assign statusQ[i]    = 1'b0;
    end else begin : g_live
      irq_src_cell u_cell (
        .clk        (clk),
        .rstN       (rstN),
        .flagIn     (srcFlag[i]),
        .wrEnable   (strobes.wrEnable),
        .wrPolarity (strobes.wrPolarity),
        .clrStatus  (strobes.clrStatus),
        .wrBit      (wrData[i]),
        .enQ        (enableQ[i]),
        .polQ       (polarityQ[i]),
        .statQ      (statusQ[i])
      );
    end
  end

endmodule

// File: rtl/irq_edge_latch_top.sv
module irq_edge_latch_top
  import irq_edge_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int RESV_STRIDE = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_SRC-1:0]    srcFlag,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWrEn,
  input  logic [NUM_SRC-1:0]    regWrData,
  output logic [NUM_SRC-1:0]    regRdData,
  output logic                  irqReq
);

  regStrobes_t        strobes;
  logic [NUM_SRC-1:0] enableQ;
  logic [NUM_SRC-1:0] polarityQ;
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] kindVal;

  irq_reg_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobes (strobes)
  );

  irq_datapath #(
    .NUM_SRC     (NUM_SRC),
    .RESV_STRIDE (RESV_STRIDE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .srcFlag   (srcFlag),
    .strobes   (strobes),
    .wrData    (regWrData),
    .enableQ   (enableQ),
    .polarityQ (polarityQ),
    .statusQ   (statusQ)
  );

  // every live source reports edge-triggered
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_kind
    assign kindVal[i] = ((i % RESV_STRIDE) != 0);
  end

  always_comb begin
    case (regSel_t'(regAddr))
      REG_ENABLE:   regRdData = enableQ;
      REG_STATUS:   regRdData = statusQ;
      REG_POLARITY: regRdData = polarityQ;
      default:      regRdData = kindVal;
    endcase
  end

  assign irqReq = |statusQ;

endmodule

// File: rtl/irq_edge_latch_checker.sv
module irq_edge_latch_checker #(
  parameter int NUM_SRC     = 32,
  parameter int RESV_STRIDE = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcFlag,
  input logic [1:0]         regAddr,
  input logic               regWrEn,
  input logic [NUM_SRC-1:0] regRdData,
  input logic               irqReq,
  input logic [NUM_SRC-1:0] statusQ,
  input logic [NUM_SRC-1:0] enableQ
);

  logic [NUM_SRC-1:0] resvMask;
  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) resvMask[i] = ((i % RESV_STRIDE) == 0);
  end

  // R5 and R8: no pending bit survives on a disabled source
  assert_no_stat_when_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ & ~enableQ) == '0);

  // R12: reserved positions never latch
  assert_resv_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ & resvMask) == '0);

  // R2: reserved enable bits stay at zero
  assert_resv_enable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ & resvMask) == '0);

  // R6: without a write and without a flag change, status holds
  assert_stat_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!regWrEn && $stable(srcFlag)) |=> $stable(statusQ));

  // R11: a request implies some enabled source
  assert_irq_needs_enable_R11: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (enableQ != '0));

  // R10: trigger kind reads edge for live sources, 0 for reserved ones
  assert_kind_fixed_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd3) |-> (regRdData == ~resvMask));

endmodule

bind irq_edge_latch_top irq_edge_latch_checker #(
  .NUM_SRC     (NUM_SRC),
  .RESV_STRIDE (RESV_STRIDE)
) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .srcFlag   (srcFlag),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regRdData (regRdData),
  .irqReq    (irqReq),
  .statusQ   (statusQ),
  .enableQ   (enableQ)
);

// File: tb/irq_edge_latch_top_bench.sv
`timescale 1ns/1ps
module irq_edge_latch_top_bench;

  localparam logic [31:0] ALL    = 32'hFFFF_FFFF;
  localparam logic [31:0] NONRES = 32'hEEEE_EEEE;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcFlag = '0;
  logic [1:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqReq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_edge_latch_top u_irq_edge_latch_top (
    .clk       (clk),
    .rstN      (rstN),
    .srcFlag   (srcFlag),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .irqReq    (irqReq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // write spans exactly one rising edge; called at a falling edge
  task automatic wrReg(input logic [1:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  task automatic step(input logic [31:0] f);
    srcFlag = f;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    logic [31:0] exp;
    logic [31:0] base;
    repeat (3) @(negedge clk);
    // R1: reset state
    rdReg(0, rd); chk("R1 enable", rd, 32'h0);
    rdReg(1, rd); chk("R1 status", rd, 32'h0);
    rdReg(2, rd); chk("R1 polarity", rd, 32'h0);
    chk("R1 irq", {31'b0, irqReq}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    rdReg(3, rd); chk("R10 kind", rd, NONRES);

    // R2 and R10: register writes
    wrReg(0, ALL);        rdReg(0, rd); chk("R2 enable mask", rd, NONRES);
    wrReg(0, 32'h1234_5678); rdReg(0, rd); chk("R2 enable pattern", rd, 32'h1234_5678 & NONRES);
    wrReg(2, ALL);        rdReg(2, rd); chk("R2 polarity mask", rd, NONRES);
    wrReg(3, 32'h0);      rdReg(3, rd); chk("R10 kind write ignored", rd, NONRES);
    rdReg(0, rd); chk("R10 kind write leaves enable", rd, 32'h1234_5678 & NONRES);

    // R3 / R4 / R6 / R11 / R12: sweep every source under both polarities
    wrReg(0, ALL);
    for (int p = 1; p >= 0; p--) begin
      wrReg(2, p ? ALL : 32'h0);
      base = p ? 32'h0 : ALL;
      step(base); step(base);
      wrReg(1, ALL);
      for (int i = 0; i < 32; i++) begin
        exp = (32'h1 << i) & NONRES;
        step(base ^ (32'h1 << i));
        rdReg(1, rd); chk(p ? "R3 R12 latch rising" : "R4 R12 latch falling", rd, exp);
        chk("R11 irq set", {31'b0, irqReq}, {31'b0, exp != 0});
        step(base);
        rdReg(1, rd); chk(p ? "R3 opposite edge ignored" : "R4 opposite edge ignored", rd, exp);
        wrReg(1, 32'h0);
        rdReg(1, rd); chk("R6 zero write keeps", rd, exp);
        wrReg(1, 32'h1 << i);
        rdReg(1, rd); chk("R6 clear", rd, 32'h0);
        chk("R11 irq clear", {31'b0, irqReq}, 32'h0);
      end
    end

    // R3 / R4: mixed polarity pattern
    wrReg(2, 32'hAAAA_AAAA);
    step(32'h0); step(32'h0); wrReg(1, ALL);
    step(ALL);
    rdReg(1, rd); chk("R3 mixed rising", rd, 32'hAAAA_AAAA & NONRES);
    step(32'h0);
    rdReg(1, rd); chk("R4 mixed falling", rd, NONRES);

    // R8: disabling clears pending bits on the write edge
    wrReg(0, 32'h0000_FFFF);
    rdReg(1, rd); chk("R8 disable clears", rd, 32'h0000_EEEE);
    rdReg(0, rd); chk("R8 enable readback", rd, 32'h0000_EEEE);

    // R7: clearing unasserted, disabled or reserved bits does nothing
    wrReg(1, 32'hFFFF_0000 | 32'h1111_1111);
    rdReg(1, rd); chk("R7 no-op clear", rd, 32'h0000_EEEE);
    wrReg(1, ALL);
    rdReg(1, rd); chk("R6 clear all", rd, 32'h0);

    // R9: event on the same edge as its clear
    wrReg(0, ALL); wrReg(2, ALL);
    step(32'h0);
    step(32'h0000_0020);
    rdReg(1, rd); chk("R9 setup", rd, 32'h0000_0020);
    srcFlag = 32'h0000_0060;          // bit 6 rises on the clearing edge
    wrReg(1, 32'h0000_0060);
    rdReg(1, rd); chk("R9 event beats clear", rd, 32'h0000_0040);
    wrReg(1, ALL);

    // R5: disabled sources never latch
    wrReg(0, 32'h0);
    step(ALL); step(32'h0); step(ALL);
    rdReg(1, rd); chk("R5 disabled", rd, 32'h0);
    chk("R5 irq low", {31'b0, irqReq}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    done = 1'b1;
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule